// File: doc/BRIEF.md
# Banked Wide Vector Register File

This block holds the wide operands of a coprocessor-style extension unit. Its 32 registers are each 128 bits wide and sit in two banks of sixteen. In one cycle an extension operation can fetch up to three wide sources and store up to two wide results. Every read port can reach any register in either bank. Each result must land in a different bank.

A 5-bit register index addresses the file. Bit 4 picks the bank, where 0 means bank A and 1 means bank B, so an index with bit 4 clear names bank A. Bits 3:0 pick the entry within that bank.

The three reads are combinational. The two writes take effect at the clock edge. The block raises a flag when both write ports aim at the same bank, and in that case it drops the secondary write. A register may be both a source and a destination of one operation: during that cycle its read returns the value held before the edge.

Top module: `wide_vreg_file`

## Requirements
- R1: The file has 32 registers of 128 bits. In a 5-bit index, bit 4 = 0 selects bank A and bit 4 = 1 selects bank B, and bits 3:0 select the entry, so index 3 and index 19 are distinct registers.
- R2: Each of the three read ports returns, in the same cycle and without a clock edge, the contents of the register named by its own index, in either bank, independently of the other read ports.
- R3: When `wr0_en` is high at a rising edge with reset low, the register at `wr0_addr` holds `wr0_data` from that edge on. Port 0 may target either bank.
- R4: When `wr1_en` is high at a rising edge with reset low and no conflict, the register at `wr1_addr` holds `wr1_data` from that edge on. Writes from both ports to different banks in the same cycle both take effect.
- R5: `wr_conflict` is high, combinationally, exactly when `wr0_en` and `wr1_en` are both high and bit 4 of both write indices is equal.
- R6: In a conflicting cycle the port 0 write proceeds and the port 1 write is discarded. This holds even when both ports name the same register.
- R7: A read of a register that is being written in the same cycle returns the value held before that clock edge.
- R8: A high `rst` at a rising edge clears all 32 registers to zero, with priority over any write enabled in that cycle.
- R9: With both write enables low, no register changes, whatever the write indices and write data are.
- R10: With only one write enable high, `wr_conflict` stays low and that write proceeds, even if the idle port's index names the same bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears every register |
| rd_addr | input | 3x5 | Register index of each read port (bit 4 bank, bits 3:0 entry) |
| rd_data | output | 3x128 | Combinational read data of each read port |
| wr0_en | input | 1 | Write enable of the primary write port |
| wr0_addr | input | 5 | Register index of the primary write |
| wr0_data | input | 128 | Data of the primary write |
| wr1_en | input | 1 | Write enable of the secondary write port |
| wr1_addr | input | 5 | Register index of the secondary write |
| wr1_data | input | 128 | Data of the secondary write |
| wr_conflict | output | 1 | High while both write ports are enabled toward the same bank |

## Verification
The bench writes the same entry number in both banks. A design that ignored the bank bit would let one write overwrite the other and fail the readback. It drives same-bank dual writes in both banks, including both ports naming one register. A design that let the secondary port win, or wrote both, would show the wrong value afterwards, and a design that flagged only identical indices would miss the conflict. It reads registers in the very cycle they are written, which catches a write-through read path. It also pairs an idle port whose index is in the same bank with an active port, which catches a conflict check that ignores the enables. Finally, it resets while both writes are enabled, which exposes a reset that loses priority to a write.

// File: rtl/wvrf_pkg.sv
package wvrf_pkg;

    // Default geometry of the wide register file.
    localparam int VREG_W       = 128;
    localparam int BANK_ENTRIES = 16;
    localparam int READ_PORTS   = 3;
    localparam int NUM_BANKS    = 2;

    // The bank select bit is the MSB of a register index.
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_sel_e;

    function automatic bank_sel_e to_bank(input logic msb);
        return msb ? BANK_B : BANK_A;
    endfunction

    // Two enabled writes collide when they name the same bank.
    function automatic logic banks_collide(input logic en0, input logic en1,
                                           input bank_sel_e b0, input bank_sel_e b1);
        return en0 && en1 && (b0 == b1);
    endfunction

endpackage

// File: rtl/wvrf_bank.sv
module wvrf_bank
    import wvrf_pkg::*;
#(
    parameter int DATA_W = VREG_W,
    parameter int DEPTH  = BANK_ENTRIES,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DEPTH-1:0][DATA_W-1:0] contents
);

    // One storage row per entry. Each row decodes its own write strobe.
    for (genvar e = 0; e < DEPTH; e++) begin : g_row
        logic hit;
        assign hit = we && (widx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                contents[e] <= '0;
            end else if (hit) begin
                contents[e] <= wdata;
            end
        end
    end

endmodule

// File: rtl/wvrf_write_route.sv
module wvrf_write_route
    import wvrf_pkg::*;
#(
    parameter int DATA_W  = VREG_W,
    parameter int DEPTH   = BANK_ENTRIES,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic                                 w0_en,
    input  logic [ADDR_W-1:0]                    w0_addr,
    input  logic [DATA_W-1:0]                    w0_data,
    input  logic                                 w1_en,
    input  logic [ADDR_W-1:0]                    w1_addr,
    input  logic [DATA_W-1:0]                    w1_data,
    output logic [NUM_BANKS-1:0]                 bank_we,
    output logic [NUM_BANKS-1:0][IDX_W-1:0]      bank_idx,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_wdata,
    output logic                                 conflict
);

    typedef struct packed {
        logic              en;
        bank_sel_e         bank;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    wr_cmd_t prim, sec;

    always_comb begin
        prim.en   = w0_en;
        prim.bank = to_bank(w0_addr[ADDR_W-1]);
        prim.idx  = w0_addr[IDX_W-1:0];
        prim.data = w0_data;
        sec.en    = w1_en;
        sec.bank  = to_bank(w1_addr[ADDR_W-1]);
        sec.idx   = w1_addr[IDX_W-1:0];
        sec.data  = w1_data;
    end

    assign conflict = banks_collide(prim.en, sec.en, prim.bank, sec.bank);

    // Each bank takes the primary write if it is aimed there. Otherwise it
    // takes the secondary write, which is dropped when the ports collide.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic take_prim, take_sec;

        always_comb begin
            take_prim     = prim.en && (prim.bank == bank_sel_e'(b));
            take_sec      = sec.en && (sec.bank == bank_sel_e'(b)) && !conflict;
            bank_we[b]    = take_prim || take_sec;
            bank_idx[b]   = take_prim ? prim.idx  : sec.idx;
            bank_wdata[b] = take_prim ? prim.data : sec.data;
        end
    end

endmodule

// File: rtl/wvrf_read_mux.sv
module wvrf_read_mux
    import wvrf_pkg::*;
#(
    parameter int DATA_W  = VREG_W,
    parameter int DEPTH   = BANK_ENTRIES,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] bank_a,
    input  logic [DEPTH-1:0][DATA_W-1:0] bank_b,
    output logic [DATA_W-1:0]            data
);

    bank_sel_e        sel;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] from_a, from_b;

    always_comb begin
        sel    = to_bank(addr[ADDR_W-1]);
        idx    = addr[IDX_W-1:0];
        from_a = bank_a[idx];
        from_b = bank_b[idx];
        unique case (sel)
            BANK_A:  data = from_a;
            BANK_B:  data = from_b;
            default: data = from_a;
        endcase
    end

endmodule

// File: rtl/wide_vreg_file.sv
module wide_vreg_file
    import wvrf_pkg::*;
#(
    parameter int DATA_W     = VREG_W,
    parameter int BANK_DEPTH = BANK_ENTRIES,
    parameter int NUM_RD     = READ_PORTS,
    localparam int ADDR_W    = $clog2(BANK_DEPTH) + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic                           wr0_en,
    input  logic [ADDR_W-1:0]              wr0_addr,
    input  logic [DATA_W-1:0]              wr0_data,
    input  logic                           wr1_en,
    input  logic [ADDR_W-1:0]              wr1_addr,
    input  logic [DATA_W-1:0]              wr1_data,
    output logic                           wr_conflict
);

    localparam int IDX_W = ADDR_W - 1;

    logic [NUM_BANKS-1:0]                         bank_we;
    logic [NUM_BANKS-1:0][IDX_W-1:0]              bank_idx;
    logic [NUM_BANKS-1:0][DATA_W-1:0]             bank_wdata;
    logic [NUM_BANKS-1:0][BANK_DEPTH-1:0][DATA_W-1:0] bank_q;

    wvrf_write_route #(
        .DATA_W (DATA_W),
        .DEPTH  (BANK_DEPTH)
    ) u_route (
        .w0_en      (wr0_en),
        .w0_addr    (wr0_addr),
        .w0_data    (wr0_data),
        .w1_en      (wr1_en),
        .w1_addr    (wr1_addr),
        .w1_data    (wr1_data),
        .bank_we    (bank_we),
        .bank_idx   (bank_idx),
        .bank_wdata (bank_wdata),
        .conflict   (wr_conflict)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wvrf_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_DEPTH)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (bank_we[b]),
            .widx     (bank_idx[b]),
            .wdata    (bank_wdata[b]),
            .contents (bank_q[b])
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        wvrf_read_mux #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_DEPTH)
        ) u_mux (
            .addr   (rd_addr[p]),
            .bank_a (bank_q[int'(BANK_A)]),
            .bank_b (bank_q[int'(BANK_B)]),
            .data   (rd_data[p])
        );
    end

endmodule

// File: rtl/wvrf_checker.sv
module wvrf_checker #(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 5,
    parameter int NUM_RD = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    input logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
    input logic                          wr0_en,
    input logic [ADDR_W-1:0]             wr0_addr,
    input logic [DATA_W-1:0]             wr0_data,
    input logic                          wr1_en,
    input logic [ADDR_W-1:0]             wr1_addr,
    input logic [DATA_W-1:0]             wr1_data,
    input logic                          wr_conflict
);

    // R5: a conflict is only raised with both ports enabled
    assert_conflict_needs_both_R5: assert property (@(posedge clk) disable iff (rst)
        wr_conflict |-> (wr0_en && wr1_en));

    // R10: a single enabled port never collides
    assert_single_port_clean_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr0_en || !wr1_en) |-> !wr_conflict);

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        // R3: primary write is visible after its edge
        assert_wr0_lands_R3: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && wr0_en) && rd_addr[p] == $past(wr0_addr))
            |-> rd_data[p] == $past(wr0_data));

        // R4: secondary write is visible after its edge when not in conflict
        assert_wr1_lands_R4: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && wr1_en && !wr_conflict) && rd_addr[p] == $past(wr1_addr))
            |-> rd_data[p] == $past(wr1_data));

        // R6: a discarded secondary write leaves its target untouched
        assert_conflict_drop_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && wr_conflict) && $stable(rd_addr[p])
             && rd_addr[p] == $past(wr1_addr) && $past(wr1_addr) != $past(wr0_addr))
            |-> $stable(rd_data[p]));

        // R9: with no write enabled, a steady read address reads steady data
        assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && !wr0_en && !wr1_en) && $stable(rd_addr[p]))
            |-> $stable(rd_data[p]));

        // R8: after a reset edge every register reads zero
        assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> rd_data[p] == '0);
    end

endmodule

bind wide_vreg_file wvrf_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_RD (NUM_RD)
) u_wvrf_checker (
    .clk         (clk),
    .rst         (rst),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr0_en      (wr0_en),
    .wr0_addr    (wr0_addr),
    .wr0_data    (wr0_data),
    .wr1_en      (wr1_en),
    .wr1_addr    (wr1_addr),
    .wr1_data    (wr1_data),
    .wr_conflict (wr_conflict)
);

// File: tb/wide_vreg_file_bench.sv
`timescale 1ns/1ps
module wide_vreg_file_bench;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2:0][4:0]      rd_addr = '0;
    logic [2:0][127:0]    rd_data;
    logic                 wr0_en = 1'b0;
    logic [4:0]           wr0_addr = '0;
    logic [127:0]         wr0_data = '0;
    logic                 wr1_en = 1'b0;
    logic [4:0]           wr1_addr = '0;
    logic [127:0]         wr1_data = '0;
    logic                 wr_conflict;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [127:0] model [32];

    always #2.5 clk = ~clk;

    wide_vreg_file u_wide_vreg_file (
        .clk         (clk),
        .rst         (rst),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .wr0_en      (wr0_en),
        .wr0_addr    (wr0_addr),
        .wr0_data    (wr0_data),
        .wr1_en      (wr1_en),
        .wr1_addr    (wr1_addr),
        .wr1_data    (wr1_data),
        .wr_conflict (wr_conflict)
    );

    typedef struct packed {
        logic        w0e;
        logic [4:0]  w0a;
        logic [31:0] w0s;
        logic        w1e;
        logic [4:0]  w1a;
        logic [31:0] w1s;
        logic [4:0]  ra0;
        logic [4:0]  ra1;
        logic [4:0]  ra2;
        logic        conf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // R1 R4: same entry in both banks, dual write across banks
        '{1'b1, 5'd3,  32'h11111111, 1'b1, 5'd19, 32'h22222222, 5'd3,  5'd19, 5'd0,  1'b0},
        // R3: primary port into bank B, secondary into bank A
        '{1'b1, 5'd23, 32'h30303030, 1'b1, 5'd7,  32'h40404040, 5'd23, 5'd7,  5'd3,  1'b0},
        // R5 R6: both in bank A
        '{1'b1, 5'd2,  32'h33333333, 1'b1, 5'd9,  32'h44444444, 5'd2,  5'd9,  5'd3,  1'b1},
        // R5 R6: both in bank B
        '{1'b1, 5'd16, 32'h55555555, 1'b1, 5'd31, 32'h66666666, 5'd16, 5'd31, 5'd19, 1'b1},
        // R9 R10: primary idle toward bank A, secondary writes bank B
        '{1'b0, 5'd3,  32'h77777777, 1'b1, 5'd20, 32'h88888888, 5'd3,  5'd20, 5'd7,  1'b0},
        // R10: secondary idle, same index as primary
        '{1'b1, 5'd15, 32'h99999999, 1'b0, 5'd15, 32'hABABABAB, 5'd15, 5'd15, 5'd23, 1'b0},
        // R7: overwrite registers read in the same cycle
        '{1'b1, 5'd3,  32'hAAAA0001, 1'b1, 5'd19, 32'hBBBB0002, 5'd3,  5'd19, 5'd3,  1'b0},
        // R9: both idle, same bank
        '{1'b0, 5'd31, 32'hDEADBEEF, 1'b0, 5'd16, 32'hFEEDFACE, 5'd31, 5'd0,  5'd16, 1'b0},
        // R2 R4: entry zero of both banks
        '{1'b1, 5'd0,  32'hCCCC1234, 1'b1, 5'd16, 32'hDDDD5678, 5'd0,  5'd16, 5'd9,  1'b0},
        // R6: both ports name the very same register
        '{1'b1, 5'd5,  32'hE1E1E1E1, 1'b1, 5'd5,  32'hE2E2E2E2, 5'd5,  5'd5,  5'd5,  1'b1}
    };

    function automatic logic [127:0] mk(input logic [31:0] s);
        return {s, ~s, s ^ 32'h5A5A5A5A, s + 32'd1};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int a = 0; a < 32; a++) model[a] = '0;
    endtask

    // Sweep every register through all three ports and compare with the model.
    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) rd_addr[p] = 5'((a + p * 11) % 32);
            #1;
            for (int p = 0; p < 3; p++) chk(req, rd_data[p], model[rd_addr[p]]);
        end
    endtask

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state, all 32 registers zero
        sweep("R8 reset state");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr0_en   = VEC[i].w0e;
            wr0_addr = VEC[i].w0a;
            wr0_data = mk(VEC[i].w0s);
            wr1_en   = VEC[i].w1e;
            wr1_addr = VEC[i].w1a;
            wr1_data = mk(VEC[i].w1s);
            rd_addr[0] = VEC[i].ra0;
            rd_addr[1] = VEC[i].ra1;
            rd_addr[2] = VEC[i].ra2;
            #1;
            // R5 R10: conflict flag from the table
            chk("R5 R10 conflict flag", 128'(wr_conflict), 128'(VEC[i].conf));
            // R7: reads before the edge show the old contents
            for (int p = 0; p < 3; p++) chk("R7 R2 pre-edge read", rd_data[p], model[rd_addr[p]]);
            @(posedge clk);
            if (wr0_en) model[wr0_addr] = wr0_data;
            if (wr1_en && (wr1_addr[4] != wr0_addr[4] || !wr0_en)) model[wr1_addr] = wr1_data;
            @(negedge clk);
            wr0_en = 1'b0;
            wr1_en = 1'b0;
            #1;
            // R1 R3 R4 R6 R9: contents after the edge
            for (int p = 0; p < 3; p++) chk("R1 R3 R4 R6 R9 post-edge read", rd_data[p], model[rd_addr[p]]);
        end

        // R1 R6 R9: the whole file matches after the table
        sweep("R1 R6 R9 full readback");

        // R8: reset wins over two enabled writes
        @(negedge clk);
        rst      = 1'b1;
        wr0_en   = 1'b1;
        wr0_addr = 5'd4;
        wr0_data = mk(32'h0F0F0F0F);
        wr1_en   = 1'b1;
        wr1_addr = 5'd20;
        wr1_data = mk(32'hF0F0F0F0);
        @(negedge clk);
        rst    = 1'b0;
        wr0_en = 1'b0;
        wr1_en = 1'b0;
        clear_model();
        sweep("R8 reset over writes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule